// File: doc/BRIEF.md
# Video RAM Access Wait Arbiter

The display controller and the CPU share one video RAM. The display reads it continuously while it paints visible pixels. A CPU write in that interval corrupts what appears on the screen as streaks, or "snow". This block holds the CPU off by asserting a wait request until the display is idle. It then issues a grant strobe that lets the CPU cycle reach the RAM. The CPU is stalled; it is never given priority over the display.

The display is idle in three cases: during horizontal retrace, during vertical retrace, and during the unused bottom scan lines of every character row. The block decodes these from the horizontal dot counter, the scan-line-within-row counter and the character-row counter of the timing chain. It registers the result before using it, so glitches on the combinational timing terms cannot reach the arbiter.

A software-controlled disable input bypasses the scheme. With it set, every request is granted in the cycle it appears.

Top module: `vram_wait_arbiter`

## Requirements
- R1: The blanking condition is true whenever the dot counter `h_count` is at or above `H_ACTIVE` (default 64).
- R2: The blanking condition is true whenever the character-row counter `char_row` is at or above `ROWS_ACTIVE` (default 16).
- R3: The blanking condition is true whenever `scan_line` is at or above `LINES_PER_ROW - TAIL_LINES` (default 12 - 4 = 8). With none of R1, R2 or R3 met, blanking is false.
- R4: The blanking condition reaches the arbiter through one register, so the arbiter sees it one clock after the counters present it.
- R5: While `cpu_vsel` is high, no grant is held and the registered blanking is false, `cpu_wait` is high and `vram_grant` is low on every cycle.
- R6: The grant is never given in the first cycle of a request. It begins on the first clock edge at which `cpu_vsel` is high and the registered blanking is true, and `cpu_wait` drops at that same edge.
- R7: Once granted, `vram_grant` stays high until `cpu_vsel` falls, even after blanking ends.
- R8: With `cpu_vsel` low, both `cpu_wait` and `vram_grant` are low.
- R9: With `wait_off` high, a request gets `vram_grant` high and `cpu_wait` low in the same cycle, whatever the blanking state.
- R10: `cpu_wait` and `vram_grant` are never high together.
- R11: Asynchronous active-low reset clears any held grant, so a request during or just after reset waits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| h_count | input | H_W | Horizontal dot counter from timing chain |
| scan_line | input | LINE_W | Scan line within the current character row |
| char_row | input | ROW_W | Character-row counter |
| cpu_vsel | input | 1 | CPU addresses video RAM |
| wait_off | input | 1 | Software disable of the wait scheme |
| cpu_wait | output | 1 | Stall request to the CPU |
| vram_grant | output | 1 | Access strobe to the video RAM |

## Verification
The hardest situation to reach is a request that is waiting when blanking begins. The bench moves the counters from an active position into a blank region while `cpu_vsel` is held. This exposes the extra register stage: the wait persists through the first edge and the grant appears only on the second. The other hard case is a grant held past the end of a blanking window. The bench reaches it by moving the counters back into the active area while the granted request stays asserted.

// File: rtl/vwa_pkg.sv
package vwa_pkg;

  typedef enum logic [0:0] {
    ARB_HOLD_OFF = 1'b0,
    ARB_GRANTED  = 1'b1
  } arb_state_e;

  function automatic logic in_hretrace(input int unsigned h, input int unsigned active);
    return h >= active;
  endfunction

  function automatic logic in_vretrace(input int unsigned row, input int unsigned rows_active);
    return row >= rows_active;
  endfunction

  function automatic logic in_row_tail(input int unsigned line, input int unsigned per_row,
                                       input int unsigned tail);
    return line >= (per_row - tail);
  endfunction

endpackage

// File: rtl/vwa_blank_gen.sv
module vwa_blank_gen
  import vwa_pkg::*;
#(
  parameter int H_W           = 7,
  parameter int LINE_W        = 4,
  parameter int ROW_W         = 5,
  parameter int H_ACTIVE      = 64,
  parameter int LINES_PER_ROW = 12,
  parameter int TAIL_LINES    = 4,
  parameter int ROWS_ACTIVE   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [H_W-1:0]    h_count,
  input  logic [LINE_W-1:0] scan_line,
  input  logic [ROW_W-1:0]  char_row,
  output logic              blank_raw,
  output logic              blank_q
);

  logic h_term, v_term, tail_term;

  always_comb begin
    h_term    = in_hretrace(32'(h_count), H_ACTIVE);
    v_term    = in_vretrace(32'(char_row), ROWS_ACTIVE);
    tail_term = in_row_tail(32'(scan_line), LINES_PER_ROW, TAIL_LINES);
    blank_raw = h_term | v_term | tail_term;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) blank_q <= 1'b0;
    else        blank_q <= blank_raw;
  end

endmodule

// File: rtl/vwa_grant_fsm.sv
module vwa_grant_fsm
  import vwa_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  input  logic window_open,
  input  logic bypass,
  output logic granted,
  output logic wait_o,
  output logic grant_o
);

  arb_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (!req)
      state_d = ARB_HOLD_OFF;
    else if (state_q == ARB_HOLD_OFF && (window_open || bypass))
      state_d = ARB_GRANTED;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ARB_HOLD_OFF;
    else        state_q <= state_d;
  end

  assign granted = (state_q == ARB_GRANTED);
  assign grant_o = req & (granted | bypass);
  assign wait_o  = req & ~granted & ~bypass;

endmodule

// File: rtl/vram_wait_arbiter.sv
module vram_wait_arbiter #(
  parameter int H_W           = 7,
  parameter int LINE_W        = 4,
  parameter int ROW_W         = 5,
  parameter int H_ACTIVE      = 64,
  parameter int LINES_PER_ROW = 12,
  parameter int TAIL_LINES    = 4,
  parameter int ROWS_ACTIVE   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [H_W-1:0]    h_count,
  input  logic [LINE_W-1:0] scan_line,
  input  logic [ROW_W-1:0]  char_row,
  input  logic              cpu_vsel,
  input  logic              wait_off,
  output logic              cpu_wait,
  output logic              vram_grant
);

  logic blank_raw;
  logic blank_q;
  logic granted;

  vwa_blank_gen #(
    .H_W(H_W), .LINE_W(LINE_W), .ROW_W(ROW_W), .H_ACTIVE(H_ACTIVE),
    .LINES_PER_ROW(LINES_PER_ROW), .TAIL_LINES(TAIL_LINES), .ROWS_ACTIVE(ROWS_ACTIVE)
  ) u_blank (
    .clk(clk), .rst_n(rst_n), .h_count(h_count), .scan_line(scan_line),
    .char_row(char_row), .blank_raw(blank_raw), .blank_q(blank_q)
  );

  vwa_grant_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .req(cpu_vsel), .window_open(blank_q),
    .bypass(wait_off), .granted(granted), .wait_o(cpu_wait), .grant_o(vram_grant)
  );

endmodule

// File: rtl/vwa_checker.sv
module vwa_checker #(
  parameter int H_W           = 7,
  parameter int LINE_W        = 4,
  parameter int ROW_W         = 5,
  parameter int H_ACTIVE      = 64,
  parameter int LINES_PER_ROW = 12,
  parameter int TAIL_LINES    = 4,
  parameter int ROWS_ACTIVE   = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic [H_W-1:0]    h_count,
  input logic [LINE_W-1:0] scan_line,
  input logic [ROW_W-1:0]  char_row,
  input logic              cpu_vsel,
  input logic              wait_off,
  input logic              cpu_wait,
  input logic              vram_grant,
  input logic              blank_raw,
  input logic              blank_q,
  input logic              granted
);

  p_hblank_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(h_count) >= H_ACTIVE) |-> blank_raw);

  p_vblank_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(char_row) >= ROWS_ACTIVE) |-> blank_raw);

  p_tail_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(scan_line) >= LINES_PER_ROW - TAIL_LINES) |-> blank_raw);

  p_wait_active_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_vsel && !wait_off && !granted && !blank_q) |=> (!cpu_vsel || wait_off || cpu_wait));

  p_grant_after_blank_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wait && blank_q) |=> (!cpu_vsel || vram_grant));

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    vram_grant |=> (!cpu_vsel || vram_grant));

  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_vsel |-> (!cpu_wait && !vram_grant));

  p_bypass_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_vsel && wait_off) |-> (vram_grant && !cpu_wait));

  p_exclusive_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(cpu_wait && vram_grant));

endmodule

bind vram_wait_arbiter vwa_checker #(
  .H_W(H_W), .LINE_W(LINE_W), .ROW_W(ROW_W), .H_ACTIVE(H_ACTIVE),
  .LINES_PER_ROW(LINES_PER_ROW), .TAIL_LINES(TAIL_LINES), .ROWS_ACTIVE(ROWS_ACTIVE)
) u_vwa_chk (
  .clk(clk), .rst_n(rst_n), .h_count(h_count), .scan_line(scan_line),
  .char_row(char_row), .cpu_vsel(cpu_vsel), .wait_off(wait_off),
  .cpu_wait(cpu_wait), .vram_grant(vram_grant), .blank_raw(blank_raw),
  .blank_q(blank_q), .granted(granted)
);

// File: tb/vram_wait_arbiter_test.sv
`timescale 1ns/1ps
module vram_wait_arbiter_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [6:0] h_count = '0;
  logic [3:0] scan_line = '0;
  logic [4:0] char_row = '0;
  logic       cpu_vsel = 1'b0;
  logic       wait_off = 1'b0;
  logic       cpu_wait, vram_grant;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  vram_wait_arbiter uut (
    .clk(clk), .rst_n(rst_n), .h_count(h_count), .scan_line(scan_line),
    .char_row(char_row), .cpu_vsel(cpu_vsel), .wait_off(wait_off),
    .cpu_wait(cpu_wait), .vram_grant(vram_grant)
  );

  typedef struct packed {
    logic [6:0] h;
    logic [3:0] ln;
    logic [4:0] row;
    logic       dis;
    logic       blank;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VEC [NV] = '{
    '{7'd10,  4'd2,  5'd3,  1'b0, 1'b0},
    '{7'd64,  4'd2,  5'd3,  1'b0, 1'b1},
    '{7'd63,  4'd2,  5'd3,  1'b0, 1'b0},
    '{7'd10,  4'd7,  5'd3,  1'b0, 1'b0},
    '{7'd10,  4'd8,  5'd3,  1'b0, 1'b1},
    '{7'd10,  4'd11, 5'd3,  1'b0, 1'b1},
    '{7'd10,  4'd2,  5'd16, 1'b0, 1'b1},
    '{7'd10,  4'd2,  5'd15, 1'b0, 1'b0},
    '{7'd10,  4'd2,  5'd3,  1'b1, 1'b0},
    '{7'd127, 4'd11, 5'd31, 1'b0, 1'b1}
  };

  task automatic chk(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic set_pos(input logic [6:0] h, input logic [3:0] ln, input logic [4:0] row);
    h_count = h; scan_line = ln; char_row = row;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    set_pos(7'd10, 4'd2, 5'd3);
    cpu_vsel = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R11: request in reset waits, no grant
    chk(cpu_wait,   1'b1, "R11 wait during reset");
    chk(vram_grant, 1'b0, "R11 grant during reset");
    cpu_vsel = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
    // R8: idle outputs
    chk(cpu_wait,   1'b0, "R8 idle wait");
    chk(vram_grant, 1'b0, "R8 idle grant");

    for (int i = 0; i < NV; i++) begin
      set_pos(VEC[i].h, VEC[i].ln, VEC[i].row);
      wait_off = VEC[i].dis;
      @(posedge clk);
      @(negedge clk);
      cpu_vsel = 1'b1;
      #1;
      if (VEC[i].dis) begin
        chk(vram_grant, 1'b1, "R9 bypass grant same cycle");
        chk(cpu_wait,   1'b0, "R9 bypass no wait");
      end else begin
        chk(cpu_wait,   1'b1, "R6 first cycle waits");
        chk(vram_grant, 1'b0, "R6 first cycle no grant");
      end
      @(posedge clk);
      @(negedge clk);
      chk(vram_grant, VEC[i].dis | VEC[i].blank, "R1 R2 R3 R5 R9 grant vs blanking");
      chk(cpu_wait,   ~(VEC[i].dis | VEC[i].blank), "R1 R2 R3 R5 R10 wait vs blanking");
      cpu_vsel = 1'b0;
      #1;
      chk(cpu_wait | vram_grant, 1'b0, "R8 release");
    end
    wait_off = 1'b0;

    // R5/R4: wait during active area, then blanking appears with one register delay
    set_pos(7'd10, 4'd2, 5'd3);
    @(negedge clk);
    cpu_vsel = 1'b1;
    repeat (3) @(negedge clk);
    chk(cpu_wait, 1'b1, "R5 wait persists in active area");
    set_pos(7'd70, 4'd2, 5'd3);
    @(negedge clk);
    chk(cpu_wait,   1'b1, "R4 still waiting one edge after blank");
    chk(vram_grant, 1'b0, "R4 no grant one edge after blank");
    @(negedge clk);
    chk(vram_grant, 1'b1, "R4 R6 grant on second edge");
    chk(cpu_wait,   1'b0, "R6 wait drops with grant");

    // R7: grant held after window closes
    set_pos(7'd10, 4'd2, 5'd3);
    repeat (4) @(negedge clk);
    chk(vram_grant, 1'b1, "R7 grant held past blanking");
    chk(cpu_wait,   1'b0, "R7 no wait while held");
    cpu_vsel = 1'b0;
    @(negedge clk);
    cpu_vsel = 1'b1;
    #1;
    chk(cpu_wait, 1'b1, "R7 new request waits after release");
    @(negedge clk);
    chk(cpu_wait, 1'b1, "R5 new request in active area waits");
    cpu_vsel = 1'b0;

    // R11: reset clears held grant
    set_pos(7'd100, 4'd2, 5'd3);
    @(negedge clk);
    cpu_vsel = 1'b1;
    repeat (2) @(negedge clk);
    chk(vram_grant, 1'b1, "R11 grant before reset");
    rst_n = 1'b0;
    #1;
    chk(vram_grant, 1'b0, "R11 reset clears grant");
    chk(cpu_wait,   1'b1, "R11 reset leaves request waiting");
    cpu_vsel = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule